// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the digital control core of a single-wire CAN physical layer. Two mode pins select one of four states: sleep, high-voltage wake-up transmit, high-speed transmit and normal transmit. From the selected mode and the transmit data it builds the bus driver enable, the high-level drive select and the waveshaping enable. It also gates the receive data output and keeps the load switch closed unless the module ground is lost.

A sleep/wake sequencer drives the regulator-enable output `cntl`. A wake-level edge on the bus, or any non-sleep mode, raises it. In sleep it stays up for a fixed number of reference ticks and then drops. This timeout applies even while the wake level persists, and a new wake edge is then needed to raise it again. All bus-side inputs arrive as comparator flags that are already digitised and deglitched. The `tick` input is a one-clock strobe at the 500 kHz timer rate.

Top module: `swb_mode_ctrl`

## Requirements
- R1: `mode_sel` decodes as 2'b00 sleep, 2'b01 high-voltage wake-up, 2'b10 high-speed, 2'b11 normal.
- R2: `drv_en` is 1 exactly when `txd` is 0, the mode is not sleep, and neither `uv_flag` nor `tsd_flag` is set. It is combinational from the inputs.
- R3: `drv_hv` is 1 only when `drv_en` is 1 and the mode is high-voltage wake-up.
- R4: `wave_en` is 1 in normal and wake-up modes and 0 in high-speed and sleep modes, whatever the data.
- R5: `rxd` is 0 exactly when `bus_dom` is 1, the receiver is open and `uv_flag` is 0. The receiver is open in any non-sleep mode, or while `hv_wake` is 1 (or was 1 in the previous cycle).
- R6: In sleep, after `hv_wake` falls, the receiver stays open until the clock edge that samples the RX_TICKS-th `tick` after the fall. It then closes and `rxd` reads 1.
- R7: `uv_flag` forces `drv_en` to 0 and `rxd` to 1. `tsd_flag` forces `drv_en` to 0 and leaves `rxd` unaffected.
- R8: `load_on` equals the inverse of `gnd_loss` in every mode.
- R9: `cntl` is 0 after reset. It is 1 one clock after any cycle whose mode is not sleep.
- R10: In sleep, a rising edge of `hv_wake` sets `cntl` to 1 at the next clock.
- R11: In sleep with `cntl` high, `cntl` drops at the clock edge that samples the HOLD_TICKS-th `tick` counted since the last non-sleep cycle or the last edge of `hv_wake`. A persisting wake level does not stop this.
- R12: Once `cntl` has dropped in sleep, it stays 0 while `hv_wake` stays high. It rises again only on a new rising edge of `hv_wake`, or when a non-sleep mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timer strobe at the reference rate |
| mode_sel | input | 2 | Mode select pins, encoding per R1 |
| txd | input | 1 | Transmit data, 0 = dominant |
| bus_dom | input | 1 | Bus dominant comparator flag |
| hv_wake | input | 1 | Deglitched high-voltage wake-level flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| tsd_flag | input | 1 | Driver thermal shutdown flag |
| gnd_loss | input | 1 | Loss-of-ground flag |
| drv_en | output | 1 | Bus driver enable |
| drv_hv | output | 1 | Select high-voltage drive level |
| wave_en | output | 1 | Waveshaping enable |
| rxd | output | 1 | Receive data, 1 = recessive or closed |
| cntl | output | 1 | Regulator enable |
| load_on | output | 1 | Load switch closed |

## Verification
The bench targets the hold timer's restart points. A sequencer that does not restart the count on the falling wake edge drops `cntl` several ticks early. One that does not time out under a persisting wake level never returns to sleep. One that treats a steady wake level as a new wake re-raises `cntl` as soon as it has dropped. For the receive window, it checks that `rxd` stays valid in the cycle where `hv_wake` falls and that the window closes on exactly the programmed tick. A design that is off by one would show a spurious high or a late close. It also sweeps every mode against every fault combination, so that a swapped mode code, or a thermal flag wrongly muting the receiver, shows up as a wrong output vector.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    MD_SLEEP = 2'b00,
    MD_WAKE  = 2'b01,
    MD_FAST  = 2'b10,
    MD_NORM  = 2'b11
  } swb_mode_e;

  // driver enable: dominant request while awake and healthy
  function automatic logic drive_req(input logic txd, input logic awake,
                                     input logic uv, input logic tsd);
    return ~txd & awake & ~uv & ~tsd;
  endfunction

  // receive level: low only for a dominant bus seen through an open receiver
  function automatic logic rx_level(input logic dom, input logic open_rx,
                                    input logic uv);
    return ~(dom & open_rx & ~uv);
  endfunction

endpackage

// File: rtl/swb_mode_decode.sv
module swb_mode_decode
  import swb_pkg::*;
(
  input  logic [1:0] mode_sel,
  output logic       awake,
  output logic       hv_sel,
  output logic       shape_en
);
  swb_mode_e mode;
  logic is_sleep, is_wake, is_fast, is_norm;

  assign mode     = swb_mode_e'(mode_sel);
  assign is_sleep = (mode == MD_SLEEP);
  assign is_wake  = (mode == MD_WAKE);
  assign is_fast  = (mode == MD_FAST);
  assign is_norm  = (mode == MD_NORM);

  assign awake    = ~is_sleep;
  assign hv_sel   = is_wake;
  assign shape_en = is_wake | is_norm;

  // R1: exactly one mode decoded
  always_comb begin
    p_one_mode_r1: assert ($countones({is_sleep, is_wake, is_fast, is_norm}) == 1 || $isunknown(mode_sel));
  end
endmodule

// File: rtl/swb_wake_seq.sv
module swb_wake_seq #(
  parameter int HOLD_TICKS = 250000,
  parameter int RX_TICKS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic awake,
  input  logic hv_wake,
  output logic cntl,
  output logic rx_open
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int RW = $clog2(RX_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [RW-1:0] RX_LOAD   = RW'(RX_TICKS);

  logic          hv_q, cntl_q;
  logic [HW-1:0] hold_cnt;
  logic [RW-1:0] rx_cnt;

  // named events for the checks below
  logic hv_rise, hv_fall, hold_expire, rx_live;
  assign hv_rise     = hv_wake & ~hv_q;
  assign hv_fall     = ~hv_wake & hv_q;
  assign hold_expire = ~awake & ~hv_rise & ~hv_fall & cntl_q & tick & (hold_cnt == HOLD_LAST);
  assign rx_live     = (rx_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q     <= 1'b0;
      cntl_q   <= 1'b0;
      hold_cnt <= '0;
      rx_cnt   <= '0;
    end else begin
      hv_q <= hv_wake;
      if (awake) begin
        cntl_q   <= 1'b1;
        hold_cnt <= '0;
      end else if (hv_rise) begin
        cntl_q   <= 1'b1;
        hold_cnt <= '0;
      end else if (hv_fall) begin
        hold_cnt <= '0;
      end else if (cntl_q && tick) begin
        if (hold_expire) begin
          cntl_q   <= 1'b0;
          hold_cnt <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end

      if (hv_fall)             rx_cnt <= RX_LOAD;
      else if (tick && rx_live) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  assign cntl    = cntl_q;
  assign rx_open = awake | hv_wake | hv_q | rx_live;

  p_active_cntl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    awake |=> cntl_q);
  p_wake_cntl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && hv_rise) |=> cntl_q);
  p_drop_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cntl_q) |-> $past(tick && !awake));
  p_stay_down_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && !cntl_q && !hv_rise) |=> !cntl_q);
  p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RX_LOAD);
endmodule

// File: rtl/swb_data_path.sv
module swb_data_path
  import swb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  input  logic hv_sel,
  input  logic shape_en,
  input  logic rx_open,
  input  logic txd,
  input  logic bus_dom,
  input  logic uv_flag,
  input  logic tsd_flag,
  input  logic gnd_loss,
  output logic drv_en,
  output logic drv_hv,
  output logic wave_en,
  output logic rxd,
  output logic load_on
);
  assign drv_en  = drive_req(txd, awake, uv_flag, tsd_flag);
  assign drv_hv  = drv_en & hv_sel;
  assign wave_en = shape_en;
  assign rxd     = rx_level(bus_dom, rx_open, uv_flag);
  assign load_on = ~gnd_loss;

  p_uv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (!drv_en && rxd));
  p_hv_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hv |-> (drv_en && wave_en));
  p_sleep_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !drv_en);
endmodule

// File: rtl/swb_mode_ctrl.sv
module swb_mode_ctrl #(
  parameter int HOLD_TICKS = 250000,
  parameter int RX_TICKS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode_sel,
  input  logic       txd,
  input  logic       bus_dom,
  input  logic       hv_wake,
  input  logic       uv_flag,
  input  logic       tsd_flag,
  input  logic       gnd_loss,
  output logic       drv_en,
  output logic       drv_hv,
  output logic       wave_en,
  output logic       rxd,
  output logic       cntl,
  output logic       load_on
);
  logic awake, hv_sel, shape_en, rx_open;

  swb_mode_decode u_dec (
    .mode_sel (mode_sel),
    .awake    (awake),
    .hv_sel   (hv_sel),
    .shape_en (shape_en)
  );

  swb_wake_seq #(.HOLD_TICKS(HOLD_TICKS), .RX_TICKS(RX_TICKS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .awake   (awake),
    .hv_wake (hv_wake),
    .cntl    (cntl),
    .rx_open (rx_open)
  );

  swb_data_path u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .awake    (awake),
    .hv_sel   (hv_sel),
    .shape_en (shape_en),
    .rx_open  (rx_open),
    .txd      (txd),
    .bus_dom  (bus_dom),
    .uv_flag  (uv_flag),
    .tsd_flag (tsd_flag),
    .gnd_loss (gnd_loss),
    .drv_en   (drv_en),
    .drv_hv   (drv_hv),
    .wave_en  (wave_en),
    .rxd      (rxd),
    .load_on  (load_on)
  );
endmodule

// File: tb/swb_mode_ctrl_tb.sv
module swb_mode_ctrl_tb;
  localparam int HOLD = 8;
  localparam int RXT  = 3;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] mode_sel = 2'b00;
  logic txd = 1, bus_dom = 0, hv_wake = 0, uv_flag = 0, tsd_flag = 0, gnd_loss = 0;
  logic drv_en, drv_hv, wave_en, rxd, cntl, load_on;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swb_mode_ctrl #(.HOLD_TICKS(HOLD), .RX_TICKS(RXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel), .txd(txd),
    .bus_dom(bus_dom), .hv_wake(hv_wake), .uv_flag(uv_flag), .tsd_flag(tsd_flag),
    .gnd_loss(gnd_loss), .drv_en(drv_en), .drv_hv(drv_hv), .wave_en(wave_en),
    .rxd(rxd), .cntl(cntl), .load_on(load_on));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; end
  endtask

  task automatic do_reset();
    rst_n = 0; mode_sel = 2'b00; hv_wake = 0; tick = 0;
    step(); step(); rst_n = 1; step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state, R8 load switch closed
    chk("R9 cntl after reset", cntl, 0);
    chk("R8 load_on after reset", load_on, 1);
    chk("R5 rxd idle after reset", rxd, 1);

    // R9 non-sleep raises cntl next clock
    mode_sel = 2'b11; step();
    chk("R9 cntl on normal mode", cntl, 1);

    // R1 R2 R3 R4 R5 R7 R8: mode x data x fault sweep
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 32; v++) begin
        logic awk, en, hv, we, rx, ld;
        mode_sel = 2'(m);
        {txd, bus_dom, uv_flag, tsd_flag, gnd_loss} = 5'(v);
        #1;
        awk = (m != 0);
        en  = !txd && awk && !uv_flag && !tsd_flag;
        hv  = en && (m == 1);
        we  = (m == 1) || (m == 3);
        rx  = !(bus_dom && awk && !uv_flag);
        ld  = !gnd_loss;
        chk($sformatf("R1 R2 R3 R4 R5 R7 R8 sweep m=%0d v=%0d", m, v),
            {drv_en, drv_hv, wave_en, rxd, load_on}, {en, hv, we, rx, ld});
      end
    end
    {txd, bus_dom, uv_flag, tsd_flag, gnd_loss} = 5'b10000;

    // R11 hold after leaving normal mode
    mode_sel = 2'b00; step();
    do_ticks(HOLD - 1);
    chk("R11 cntl held before last tick", cntl, 1);
    do_ticks(1);
    chk("R11 cntl drops on last tick", cntl, 0);

    // R10 wake edge in sleep, R5 rxd follows bus while wake present
    do_reset();
    hv_wake = 1; bus_dom = 1; step();
    chk("R10 cntl on wake edge", cntl, 1);
    chk("R5 rxd follows bus in wake", rxd, 0);
    uv_flag = 1; #1;
    chk("R7 uv mutes rxd", rxd, 1);
    uv_flag = 0; tsd_flag = 1; #1;
    chk("R7 tsd keeps rxd", rxd, 0);
    tsd_flag = 0;
    // R11 forced timeout while wake persists
    do_ticks(HOLD - 1);
    chk("R11 cntl held with wake on", cntl, 1);
    do_ticks(1);
    chk("R11 forced timeout under wake", cntl, 0);
    // R12 steady wake does not relight
    do_ticks(10);
    chk("R12 cntl stays low with steady wake", cntl, 0);
    // R6 receive window after wake falls
    hv_wake = 0; #1;
    chk("R6 rxd valid in fall cycle", rxd, 0);
    step();
    do_ticks(RXT - 1);
    chk("R6 rx window still open", rxd, 0);
    do_ticks(1);
    chk("R6 rx window closed", rxd, 1);
    chk("R12 cntl low after wake fall", cntl, 0);
    hv_wake = 1; step();
    chk("R12 new wake edge relights", cntl, 1);

    // R11 count restarts on wake fall
    do_ticks(5);
    hv_wake = 0; step();
    do_ticks(HOLD - 1);
    chk("R11 hold restarted at wake fall", cntl, 1);
    do_ticks(1);
    chk("R11 hold expires after fall", cntl, 0);
    bus_dom = 0;

    // R1 R2 R3: wake mode drives high level on dominant
    mode_sel = 2'b01; txd = 0; #1;
    chk("R3 drv_hv in wake mode", {drv_en, drv_hv}, 2'b11);
    mode_sel = 2'b10; #1;
    chk("R4 fast mode no shaping", {drv_en, drv_hv, wave_en}, 3'b100);
    txd = 1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule